// File: doc/BRIEF.md
# I2C Master Repeated-Start Generator

This block produces an I2C repeated-start condition for a bus master that is already holding the bus. Software sets a request bit in a small control field. The block then steps through four phases on open-drain SCL and SDA, which it drives through output-enable signals. First it pulls SCL low. Next it lets SDA float high. Then it releases SCL and holds both lines high. Finally it pulls SDA low while SCL stays high. A reloadable down-counter times every phase, and each phase lasts divisor+1 system clocks.

Pin inputs pass through a two-flop synchronizer. The sequencer moves on only when it sees the pins reach the expected level, so a slave that stretches SCL, or a device that holds SDA low, simply stalls it. Two bus-collision cases end the sequence early: SDA is low when SCL rises, or SCL falls before this master has pulled SDA low. While the sequence runs, writes to the data buffer are refused and raise a write-collision flag, and writes to the control field are dropped. When the sequence finishes, the request bit clears, the completion interrupt flag sets, and SDA is left held low for the first data bit.

Top module: `i2c_rstart_gen`

## Requirements
- R1: After reset, scl_oe, sda_oe, ctrl_q, buf_q, start_seen, irq, bcol and wcol are all 0.
- R2: Writing ctrl_wdata bit 1 = 1 while xfer_busy is high starts nothing. ctrl_q bit 1 stays 0 and scl_oe stays 0.
- R3: A write with ctrl_wdata bit 1 = 1 in the idle state sets ctrl_q bit 1 and scl_oe, and clears sda_oe, on the next clock. SCL stays driven low for as long as SDA is seen low on the pin.
- R4: After releasing SCL, the block waits until SCL is seen high. While another device holds SCL low, sda_oe stays 0 and ctrl_q bit 1 stays 1.
- R5: sda_oe is set only while SCL is released. It then stays set for exactly divisor+1 clocks before ctrl_q bit 1 clears. At that point irq sets, sda_oe stays 1 and scl_oe stays 0.
- R6: start_seen sets when the synchronized pins show SDA falling while SCL is high. In a normal sequence with divisor >= 3 it is set by the time ctrl_q bit 1 clears.
- R7: If SDA is seen low when SCL is seen rising, bcol sets, both enables drop, ctrl_q bit 1 clears, and irq and start_seen stay 0.
- R8: If SCL is seen low during the both-high phase, before SDA is pulled low, bcol sets, both enables drop and ctrl_q bit 1 clears.
- R9: A buffer write while the sequence runs leaves buf_q unchanged and sets wcol. This includes the sequence's final clock. An idle buffer write loads buf_q and leaves wcol alone.
- R10: A control write while the sequence runs leaves ctrl_q bits 0, 2, 3 and 4 unchanged. This includes the final clock. An idle control write loads those bits.
- R11: flag_clr clears irq, bcol, wcol and start_seen. A new event arriving in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| divisor | input | 7 | Baud divisor; each phase lasts divisor+1 clocks |
| xfer_busy | input | 1 | A byte transfer is in progress; new requests are refused |
| ctrl_wr | input | 1 | Control field write strobe |
| ctrl_wdata | input | 5 | Control write data; bit 1 is the restart request |
| ctrl_q | output | 5 | Control field; bit 1 reads 1 while the sequence runs |
| buf_wr | input | 1 | Data buffer write strobe |
| buf_wdata | input | 8 | Data buffer write data |
| buf_q | output | 8 | Data buffer contents |
| flag_clr | input | 1 | Clears the status and interrupt flags |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| start_seen | output | 1 | Start condition detected on the pins (sticky) |
| irq | output | 1 | Sequence completed (sticky) |
| bcol | output | 1 | Bus collision during the sequence (sticky) |
| wcol | output | 1 | Buffer write refused while busy (sticky) |

## Verification
The sequence finishing and a software write can land in the same clock. In that cycle the request bit is still set, so both a buffer write and a control write must be refused even though the block is idle on the next clock. The bench counts SDA-low clocks from the first cycle sda_oe reads 1 and issues both writes exactly on the divisor+1-th of them. It then expects ctrl_q bit 1 to read 0, wcol to read 1, and buf_q and the other control bits to be unchanged. A buffer write one cycle later must then take effect.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

  // Phases of the repeated-start sequence
  typedef enum logic [2:0] {
    RS_IDLE     = 3'd0,
    RS_PULL_SCL = 3'd1,  // SCL driven low, waiting to see it low
    RS_SDA_HI   = 3'd2,  // SDA floating high for one baud period
    RS_SDA_WAIT = 3'd3,  // period over, waiting for SDA to read high
    RS_SCL_RISE = 3'd4,  // SCL released, waiting to see it high
    RS_HOLD_HI  = 3'd5,  // both lines high for one baud period
    RS_SDA_LO   = 3'd6   // SDA driven low for one baud period
  } rs_state_e;

  localparam int CTRL_W  = 5;
  localparam int REQ_BIT = 1;

  // Clocks spent in one timed phase for a given divisor
  function automatic int phase_clocks(input int div);
    return div + 1;
  endfunction

  // Start condition on the pins: SDA high-to-low while SCL high
  function automatic logic sda_fell_high(input logic sda_now,
                                         input logic sda_prev,
                                         input logic scl_now);
    return !sda_now && sda_prev && scl_now;
  endfunction

endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int CHAIN_W = STAGES * WIDTH;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[CHAIN_W-WIDTH-1:0], d};
  end

  assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/i2c_rs_baud.sv
module i2c_rs_baud #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= div;
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign tick = run && (cnt == '0);

  // R5
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> !tick);

  // R5
  load_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && div != '0) |=> !tick);
endmodule

// File: rtl/i2c_rs_seq.sv
module i2c_rs_seq
  import i2c_rs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic scl_s,
  input  logic sda_s,
  input  logic tick,
  output logic cnt_load,
  output logic scl_oe,
  output logic sda_oe,
  output logic busy,
  output logic done,
  output logic coll
);
  rs_state_e state, state_nx;
  logic      scl_oe_nx, sda_oe_nx;

  always_comb begin
    state_nx  = state;
    scl_oe_nx = scl_oe;
    sda_oe_nx = sda_oe;
    cnt_load  = 1'b0;
    done      = 1'b0;
    coll      = 1'b0;
    unique case (state)
      RS_IDLE: begin
        if (start_req) begin
          state_nx  = RS_PULL_SCL;
          scl_oe_nx = 1'b1;
          sda_oe_nx = 1'b0;
        end
      end
      RS_PULL_SCL: begin
        if (!scl_s) begin
          cnt_load = 1'b1;
          state_nx = RS_SDA_HI;
        end
      end
      RS_SDA_HI: begin
        if (tick) begin
          if (sda_s) begin
            scl_oe_nx = 1'b0;
            state_nx  = RS_SCL_RISE;
          end else begin
            state_nx  = RS_SDA_WAIT;
          end
        end
      end
      RS_SDA_WAIT: begin
        if (sda_s) begin
          scl_oe_nx = 1'b0;
          state_nx  = RS_SCL_RISE;
        end
      end
      RS_SCL_RISE: begin
        if (scl_s) begin
          if (!sda_s) begin
            coll = 1'b1;
          end else begin
            cnt_load = 1'b1;
            state_nx = RS_HOLD_HI;
          end
        end
      end
      RS_HOLD_HI: begin
        if (!scl_s) begin
          coll = 1'b1;
        end else if (tick) begin
          cnt_load  = 1'b1;
          sda_oe_nx = 1'b1;
          state_nx  = RS_SDA_LO;
        end
      end
      RS_SDA_LO: begin
        if (tick) begin
          done     = 1'b1;
          state_nx = RS_IDLE;
        end
      end
      default: state_nx = RS_IDLE;
    endcase
    if (coll) begin
      state_nx  = RS_IDLE;
      scl_oe_nx = 1'b0;
      sda_oe_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RS_IDLE;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      state  <= state_nx;
      scl_oe <= scl_oe_nx;
      sda_oe <= sda_oe_nx;
    end
  end

  assign busy = (state != RS_IDLE);

  // R5
  sda_pull_scl_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> (!scl_oe && scl_s));

  // R3
  scl_free_needs_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_oe) && busy) |-> $past(sda_s));

  // R7
  coll_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coll |=> (!scl_oe && !sda_oe && !busy));

  // R5
  done_sda_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (sda_oe && !scl_oe && !busy));

  // R8
  hold_scl_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RS_HOLD_HI && !scl_s) |-> coll);
endmodule

// File: rtl/i2c_rs_regs.sv
module i2c_rs_regs
  import i2c_rs_pkg::*;
#(
  parameter int BUF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              buf_wr,
  input  logic [BUF_W-1:0]  buf_wdata,
  input  logic              flag_clr,
  input  logic              xfer_busy,
  input  logic              busy,
  input  logic              done,
  input  logic              coll,
  input  logic              scl_s,
  input  logic              sda_s,
  output logic              start_req,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [BUF_W-1:0]  buf_q,
  output logic              start_seen,
  output logic              irq,
  output logic              bcol,
  output logic              wcol
);
  logic sda_prev;
  logic start_ev;
  logic wcol_ev;

  assign start_req = ctrl_wr && ctrl_wdata[REQ_BIT] && !busy && !xfer_busy;
  assign wcol_ev   = buf_wr && busy;

  for (genvar b = 0; b < CTRL_W; b++) begin : g_ctrl
    if (b == REQ_BIT) begin : g_req
      assign ctrl_q[b] = busy;
    end else begin : g_plain
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                bit_q <= 1'b0;
        else if (ctrl_wr && !busy) bit_q <= ctrl_wdata[b];
      end
      assign ctrl_q[b] = bit_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               buf_q <= '0;
    else if (buf_wr && !busy) buf_q <= buf_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_prev <= 1'b1;
    else        sda_prev <= sda_s;
  end

  assign start_ev = sda_fell_high(sda_s, sda_prev, scl_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_seen <= 1'b0;
      irq        <= 1'b0;
      bcol       <= 1'b0;
      wcol       <= 1'b0;
    end else begin
      start_seen <= start_ev || (start_seen && !flag_clr);
      irq        <= done     || (irq && !flag_clr);
      bcol       <= coll     || (bcol && !flag_clr);
      wcol       <= wcol_ev  || (wcol && !flag_clr);
    end
  end

  // R9
  buf_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && busy) |=> ($stable(buf_q) && wcol));

  // R10
  ctrl_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && busy && !done && !coll) |=> $stable(ctrl_q));

  // R2
  xfer_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && xfer_busy && !busy) |=> !ctrl_q[REQ_BIT]);

  // R11
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !done && !coll) |=> (!irq && !bcol));
endmodule

// File: rtl/i2c_rstart_gen.sv
module i2c_rstart_gen
  import i2c_rs_pkg::*;
#(
  parameter int DIV_W = 7,
  parameter int BUF_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              xfer_busy,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  input  logic              buf_wr,
  input  logic [BUF_W-1:0]  buf_wdata,
  output logic [BUF_W-1:0]  buf_q,
  input  logic              flag_clr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              start_seen,
  output logic              irq,
  output logic              bcol,
  output logic              wcol
);
  logic scl_s, sda_s;
  logic start_req, busy, done, coll;
  logic cnt_load, tick;

  i2c_rs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({scl_i, sda_i}),
    .q    ({scl_s, sda_s})
  );

  i2c_rs_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .load (cnt_load),
    .div  (divisor),
    .tick (tick)
  );

  i2c_rs_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_req(start_req),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .tick     (tick),
    .cnt_load (cnt_load),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .busy     (busy),
    .done     (done),
    .coll     (coll)
  );

  i2c_rs_regs #(.BUF_W(BUF_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .ctrl_wdata(ctrl_wdata),
    .buf_wr    (buf_wr),
    .buf_wdata (buf_wdata),
    .flag_clr  (flag_clr),
    .xfer_busy (xfer_busy),
    .busy      (busy),
    .done      (done),
    .coll      (coll),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .start_req (start_req),
    .ctrl_q    (ctrl_q),
    .buf_q     (buf_q),
    .start_seen(start_seen),
    .irq       (irq),
    .bcol      (bcol),
    .wcol      (wcol)
  );

  // R6
  start_not_on_coll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coll |-> !sda_oe);
endmodule

// File: tb/i2c_rstart_gen_tb_top.sv
`timescale 1ns/1ps
module i2c_rstart_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] divisor = 7'd4;
  logic       xfer_busy = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [4:0] ctrl_wdata = '0;
  logic [4:0] ctrl_q;
  logic       buf_wr = 1'b0;
  logic [7:0] buf_wdata = '0;
  logic [7:0] buf_q;
  logic       flag_clr = 1'b0;
  logic       scl_oe, sda_oe, start_seen, irq, bcol, wcol;
  logic       ext_scl_lo = 1'b0;
  logic       ext_sda_lo = 1'b0;
  logic       scl_i, sda_i;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // open-drain bus model with a weak pull-up
  assign scl_i = ~(scl_oe | ext_scl_lo);
  assign sda_i = ~(sda_oe | ext_sda_lo);

  i2c_rstart_gen dut_i (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .xfer_busy(xfer_busy),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_q(buf_q),
    .flag_clr(flag_clr), .scl_i(scl_i), .sda_i(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .start_seen(start_seen),
    .irq(irq), .bcol(bcol), .wcol(wcol)
  );

  // {divisor[6:0], other control bits[4:0]}; bit 1 is forced on when sent
  localparam logic [11:0] VEC [4] = '{
    {7'd3,  5'b00001},
    {7'd6,  5'b11100},
    {7'd10, 5'b10101},
    {7'd21, 5'b01000}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_ctrl(input logic [4:0] w);
    ctrl_wdata = w; ctrl_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic wait_sda_pull();
    for (int g = 0; g < 5000 && !sda_oe; g++) @(negedge clk);
  endtask

  task automatic wait_scl_free();
    for (int g = 0; g < 5000 && scl_oe; g++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 5000 && ctrl_q[1]; g++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 enables", {scl_oe, sda_oe}, 0);
    chk("R1 ctrl_q", ctrl_q, 0);
    chk("R1 buf_q", buf_q, 0);
    chk("R1 flags", {start_seen, irq, bcol, wcol}, 0);

    // R2 request refused during a transfer
    xfer_busy = 1'b1;
    send_ctrl(5'b00010);
    chk("R2 req bit", ctrl_q[1], 0);
    step(4);
    chk("R2 scl_oe", scl_oe, 0);
    xfer_busy = 1'b0;

    // table of divisors and control patterns
    for (int i = 0; i < 4; i++) begin
      logic [6:0] dv;
      logic [4:0] w;
      int n;
      dv = VEC[i][11:5];
      w  = VEC[i][4:0] | 5'b00010;
      divisor = dv;
      pulse_clr();
      send_ctrl(w);
      chk("R3 accept", {ctrl_q[1], scl_oe, sda_oe}, 3'b110);
      wait_sda_pull();
      n = 0;
      while (ctrl_q[1] && n < 1000) begin n++; @(negedge clk); end
      chk("R5 sda low clocks", n, int'(dv) + 1);
      chk("R5 irq", irq, 1);
      chk("R5 lines after", {sda_oe, scl_oe}, 2'b10);
      chk("R6 start_seen", start_seen, 1);
      chk("R10 ctrl kept", ctrl_q, int'(w & 5'b11101));
      chk("R7 no bcol", bcol, 0);
    end

    // R3 SDA held low by another device keeps SCL driven
    divisor = 7'd4;
    pulse_clr();
    ext_sda_lo = 1'b1;
    send_ctrl(5'b00010);
    step(40);
    chk("R3 scl held", {scl_oe, ctrl_q[1]}, 2'b11);
    ext_sda_lo = 1'b0;
    wait_idle();
    chk("R3 completes", irq, 1);

    // R4 SCL stretched by another device
    pulse_clr();
    ext_scl_lo = 1'b1;
    send_ctrl(5'b00010);
    wait_scl_free();
    step(30);
    chk("R4 stall", {sda_oe, ctrl_q[1]}, 2'b01);
    ext_scl_lo = 1'b0;
    wait_idle();
    chk("R4 completes", irq, 1);

    // R7 SDA low when SCL rises
    pulse_clr();
    ext_scl_lo = 1'b1;
    send_ctrl(5'b00010);
    wait_scl_free();
    ext_sda_lo = 1'b1;
    step(5);
    ext_scl_lo = 1'b0;
    step(8);
    chk("R7 bcol", bcol, 1);
    chk("R7 released", {scl_oe, sda_oe, ctrl_q[1]}, 0);
    chk("R7 no irq/start", {irq, start_seen}, 0);
    ext_sda_lo = 1'b0;
    step(4);

    // R8 SCL dropped during the both-high phase
    divisor = 7'd20;
    pulse_clr();
    send_ctrl(5'b00010);
    wait_scl_free();
    step(6);
    ext_scl_lo = 1'b1;
    step(6);
    chk("R8 bcol", bcol, 1);
    chk("R8 released", {scl_oe, sda_oe, ctrl_q[1]}, 0);
    chk("R8 no irq", irq, 0);
    ext_scl_lo = 1'b0;
    step(4);

    // R9 / R10 guarded writes, including the final cycle
    divisor = 7'd6;
    pulse_clr();
    buf_wdata = 8'hA5; buf_wr = 1'b1;
    step(1);
    buf_wr = 1'b0;
    chk("R9 idle write", buf_q, 8'hA5);
    chk("R9 no wcol idle", wcol, 0);
    send_ctrl(5'b00010);
    send_ctrl(5'b11101);
    chk("R10 busy ctrl write", ctrl_q, 5'b00010);
    buf_wdata = 8'h3C; buf_wr = 1'b1;
    step(1);
    buf_wr = 1'b0;
    chk("R9 busy write", buf_q, 8'hA5);
    chk("R9 wcol", wcol, 1);
    pulse_clr();
    chk("R11 wcol cleared", wcol, 0);
    wait_sda_pull();
    step(int'(divisor));
    buf_wdata = 8'h77; buf_wr = 1'b1;
    ctrl_wdata = 5'b10000; ctrl_wr = 1'b1;
    step(1);
    buf_wr = 1'b0; ctrl_wr = 1'b0;
    chk("R9 final-cycle done", ctrl_q[1], 0);
    chk("R9 final-cycle buf", buf_q, 8'hA5);
    chk("R9 final-cycle wcol", wcol, 1);
    chk("R10 final-cycle ctrl", ctrl_q, 0);
    buf_wr = 1'b1;
    step(1);
    buf_wr = 1'b0;
    chk("R9 write after done", buf_q, 8'h77);

    // R11 clear of all flags
    chk("R11 flags set", {irq, start_seen}, 2'b11);
    pulse_clr();
    chk("R11 cleared", {start_seen, irq, bcol, wcol}, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule